// File: doc/BRIEF.md
# Dual Prescaled Clock Enable Generator

This block turns one master clock into two independent single-cycle enable strobes, called lane A and lane B. A free-running power-of-two prescaler provides eleven tap strobes, at the master rate divided by 1, 2, 4 and so on up to 1024. Each lane picks one tap and counts its pulses with a programmable linear divider. The lane fires one enable pulse every N tap pulses, where N is the divide factor. A divide factor of zero, or a reserved tap code, keeps the lane silent.

All eleven prescaler taps are also exported as single-cycle strobes, so that neighbouring PWM channels can use any tap directly. The block produces only enables, never derived clocks. Logic downstream stays on the master clock and uses these strobes as qualifiers. The configuration arrives as one 32-bit word that a register file elsewhere holds.

Top module: `dual_rate_strobe_gen`

## Requirements
- R1: While `rst` is high, all tap strobes and both lane enables are low.
- R2: Counting rising edges after reset release from k = 1, tap strobe n (bit n of `tap_stb_o`, n = 0..10) is high in the cycle following edge k exactly when k is a multiple of 2^n. Tap 0 is therefore high on every cycle after the first edge.
- R3: Lane A takes its tap code from `cfg_i[11:8]` and its divide factor from `cfg_i[7:0]`. Lane B takes its tap code from `cfg_i[27:24]` and its divide factor from `cfg_i[23:16]`. The other bits are ignored.
- R4: A divide factor of 0 keeps that lane's enable permanently low.
- R5: With a divide factor of 1, the lane enable is high in the cycle right after each cycle in which the selected tap strobe is high.
- R6: With a divide factor N from 2 to 255, the lane enable pulses once for every N pulses of the selected tap. It pulses one cycle after the Nth, 2Nth, and later tap pulses, counted from the lane's last restart.
- R7: Tap codes 11 to 15 are reserved, and a lane set to a reserved code never asserts its enable.
- R8: A change to any bit of a lane's field pair is seen at the next edge. That edge restarts the lane's counter from zero with the enable low. With tap code 0, the first enable after the change then comes N edges after the restarting edge.
- R9: The two lanes are independent. Changing one lane's fields does not disturb the pulse pattern of the other lane.
- R10: Every enable pulse is preceded, in the cycle before, by a pulse of the selected tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Configuration word holding both lanes' tap code and divide factor |
| tap_stb_o | output | 11 | Prescaler tap strobes; bit n pulses at the master rate divided by 2^n |
| en_a_o | output | 1 | Lane A enable strobe |
| en_b_o | output | 1 | Lane B enable strobe |

## Verification
The hardest case to reach is a lane restart in the middle of a run while the other lane keeps counting. The restart must land at a known edge so that the new interval can be measured exactly. The bench starts both lanes on the undivided tap and lets them run. It then rewrites only lane A's divide factor at a chosen negative edge and checks that lane A stays silent for exactly N edges, then fires. Lane B's pattern is checked against its own arithmetic formula in the same cycles. The slowest tap is covered by a run of more than two full prescaler wraps.

// File: rtl/dual_rate_pkg.sv
package dual_rate_pkg;
  // Layout of one lane's field pair inside the configuration word
  localparam int LANES       = 2;
  localparam int LANE_STRIDE = 16;
  localparam int DIV_OFS     = 0;
  localparam int SEL_OFS     = 8;
endpackage

// File: rtl/pow2_prescaler.sv
module pow2_prescaler #(
  parameter int PRE_BITS = 10,
  localparam int NUM_TAPS = PRE_BITS + 1
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [PRE_BITS-1:0] chain_q;
  logic [NUM_TAPS-1:0] tap_d;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_q + 1'b1;
  end

  // tap n fires when the low n bits of the chain are all ones
  assign tap_d[0] = 1'b1;
  for (genvar n = 1; n < NUM_TAPS; n++) begin : g_tap
    assign tap_d[n] = &chain_q[n-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) tap_o <= '0;
    else     tap_o <= tap_d;
  end

  // a slower tap can only fire together with every faster one
  for (genvar n = 1; n < NUM_TAPS; n++) begin : g_nest_chk
    a_r2_tap_nested: assert property (@(posedge clk) disable iff (rst)
      tap_o[n] |-> tap_o[n-1]);
  end
  a_r1_taps_quiet: assert property (@(posedge clk)
    rst |=> (tap_o == '0));
endmodule

// File: rtl/lane_divider.sv
module lane_divider #(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                en_o
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             hit;
  logic             chg;
  logic             last;

  // reserved codes match no tap and leave hit low
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel_q == SEL_W'(i)) hit = tap_i[i];
    end
  end

  assign chg  = (sel_i != sel_q) || (div_i != div_q);
  assign last = (cnt_q == div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else begin
      sel_q <= sel_i;
      div_q <= div_i;
      if (chg || div_q == '0) begin
        cnt_q <= '0;
        en_o  <= 1'b0;
      end else if (hit) begin
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        en_o  <= last;
      end else begin
        en_o  <= 1'b0;
      end
    end
  end

  a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
    (div_i == '0 && div_q == '0) |=> !en_o);
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    chg |=> (cnt_q == '0 && !en_o));
  a_r10_en_after_tap: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $past(hit));
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (div_q != '0) |-> (cnt_q < div_q));
endmodule

// File: rtl/dual_rate_strobe_gen.sv
module dual_rate_strobe_gen
  import dual_rate_pkg::*;
#(
  parameter int PRE_BITS = 10,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8,
  parameter int CFG_W    = 32,
  localparam int NUM_TAPS = PRE_BITS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_W-1:0]    cfg_i,
  output logic [NUM_TAPS-1:0] tap_stb_o,
  output logic                en_a_o,
  output logic                en_b_o
);
  logic [LANES-1:0] lane_en;

  pow2_prescaler #(.PRE_BITS(PRE_BITS)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .tap_o (tap_stb_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int BASE = l * LANE_STRIDE;
    lane_divider #(
      .NUM_TAPS (NUM_TAPS),
      .SEL_W    (SEL_W),
      .DIV_W    (DIV_W)
    ) u_div (
      .clk   (clk),
      .rst   (rst),
      .tap_i (tap_stb_o),
      .sel_i (cfg_i[BASE+SEL_OFS +: SEL_W]),
      .div_i (cfg_i[BASE+DIV_OFS +: DIV_W]),
      .en_o  (lane_en[l])
    );
  end

  assign en_a_o = lane_en[0];
  assign en_b_o = lane_en[1];

  a_r1_lanes_quiet: assert property (@(posedge clk)
    rst |=> (lane_en == '0));
endmodule

// File: tb/dual_rate_strobe_gen_tb.sv
module dual_rate_strobe_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg = '0;
  logic [10:0] tap;
  logic        en_a, en_b;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_rate_strobe_gen u_dut (
    .clk(clk), .rst(rst), .cfg_i(cfg),
    .tap_stb_o(tap), .en_a_o(en_a), .en_b_o(en_b)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_en(int sel, int dv, int k);
    int p, m;
    if (sel > 10 || dv == 0 || k < 2) return 0;
    p = 1 << sel;
    if ((k - 1) % p != 0) return 0;
    m = (k - 1) / p;
    return (m >= 1) && (m % dv == 0);
  endfunction

  function automatic logic [10:0] exp_tap(int k);
    logic [10:0] v = '0;
    for (int n = 0; n < 11; n++) v[n] = (k >= 1) && (k % (1 << n) == 0);
    return v;
  endfunction

  function automatic string tag(int sel, int dv);
    if (dv == 0) return "R4";
    if (sel > 10) return "R7";
    if (dv == 1) return "R5";
    return "R6";
  endfunction

  function automatic logic [31:0] pack(int sa, int da, int sb, int db);
    logic [3:0] s1 = sa[3:0];
    logic [7:0] d1 = da[7:0];
    logic [3:0] s2 = sb[3:0];
    logic [7:0] d2 = db[7:0];
    return {4'h0, s2, d2, 4'h0, s1, d1};
  endfunction

  // R3 layout: lane A {11:8 tap, 7:0 div}, lane B {27:24 tap, 23:16 div}
  task automatic run_case(int sa, int da, int sb, int db, int len);
    @(negedge clk);
    rst = 1'b1;
    cfg = pack(sa, da, sb, db) | 32'hF000_F000;  // R3: unused bits set, must be ignored
    repeat (3) @(negedge clk);
    check(tap == '0 && !en_a && !en_b, "R1 reset state", {tap, en_a, en_b}, 0);
    rst = 1'b0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      check(tap == exp_tap(k), "R2 tap strobes", tap, exp_tap(k));
      check(en_a == exp_en(sa, da, k), {tag(sa, da), " R3 lane A"}, en_a, exp_en(sa, da, k));
      check(en_b == exp_en(sb, db, k), {tag(sb, db), " R3 R9 lane B"}, en_b, exp_en(sb, db, k));
    end
  endtask

  initial begin
    // sweep of the fast taps and small divide factors, lanes configured differently
    for (int s = 0; s < 5; s++) begin
      for (int d = 0; d < 5; d++) begin
        int sb = 4 - s;
        int db = (d + 2) % 5;
        int la = (1 << s) * d;
        int lb = (1 << sb) * db;
        run_case(s, d, sb, db, 2 * ((la > lb) ? la : lb) + 8);
      end
    end
    // slowest taps across two prescaler wraps
    run_case(10, 2, 9, 1, 4104);
    // largest divide factor
    run_case(0, 255, 1, 3, 520);
    // reserved tap codes
    for (int s = 11; s < 16; s++) run_case(s, 1, 15 - s + 11 > 15 ? 0 : 26 - s, 1, 64);

    // R8 restart mid-run, R9 lane B undisturbed
    @(negedge clk);
    rst = 1'b1;
    cfg = pack(0, 3, 0, 2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 10; k++) @(negedge clk);
    cfg = pack(0, 6, 0, 2);
    for (int k = 11; k <= 17; k++) begin
      @(negedge clk);
      check(en_a == (k == 17), "R8 restart interval", en_a, (k == 17));
      check(en_b == exp_en(0, 2, k), "R9 lane B after lane A change", en_b, exp_en(0, 2, k));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule